// File: doc/BRIEF.md
# Source Operand Addressing Sequencer

This block obtains the source operand of a two-operand instruction in a 16-bit word-oriented datapath. A request carries a 3-bit addressing mode and a register number. The block holds its own bank of general registers, and the highest-numbered register serves as the program counter. It steps through a short sequence for the chosen mode. That sequence can read a PC-relative extension word, follow one level of indirection, and apply the post-increment or pre-decrement side effect to a register. When the sequence ends, the block presents the operand together with a single-cycle valid pulse.

Memory is reached through a word-read port. The block raises a read strobe with an address, holds both until an acknowledge arrives, and takes the data in the cycle of the acknowledge. The block accepts a new request only while it is idle. A request made during a sequence is ignored.

Top module: `srcop_fetch`

## Requirements
- R1: After reset, busy, mem_rd and op_valid are low, and register i holds INIT_BASE + i*INIT_STRIDE (0x0010 + i*0x0100 by default; register 7 is the PC).
- R2: Mode 0 (register) returns the register contents. It performs no memory read and raises op_valid on the cycle after acceptance.
- R3: Mode 1 (register deferred) performs one read at the register's value and returns the word read.
- R4: Mode 2 (autoincrement) reads at the register's value and adds 2 to the register. On register 7 this yields an immediate operand and advances the PC by 2.
- R5: Mode 3 (autoincrement deferred) reads a pointer at the register's value, adds 2 to the register, and then reads the operand at the pointer.
- R6: Mode 4 (autodecrement) subtracts 2 from the register, including register 7, and reads at the new value.
- R7: Mode 5 (autodecrement deferred) subtracts 2 from the register, reads a pointer at the new value, and then reads the operand at the pointer.
- R8: Mode 6 (indexed) reads an extension word at the PC and adds 2 to the PC. It then reads the operand at the extension word plus the register, where the register value is the one after the PC update.
- R9: Mode 7 (indexed deferred) behaves as mode 6 and then reads the operand through the word found at the indexed address. This takes three reads in total.
- R10: While mem_rd is high and no mem_ack has arrived, mem_rd stays high and mem_addr stays stable. Data is taken only in the cycle in which mem_ack is high.
- R11: op_valid is high for exactly one cycle per accepted request. It rises on the cycle after the final acknowledge (or after acceptance, for mode 0), and op_data is valid while it is high.
- R12: A request made while busy is ignored. It changes no register and produces no extra op_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_mode | input | 3 | Addressing mode 0..7 |
| req_reg | input | AW | Register number (AW=3) |
| busy | output | 1 | Sequence in progress |
| mem_rd | output | 1 | Word read request, held until acknowledge |
| mem_addr | output | DW | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DW | Read data |
| op_valid | output | 1 | One-cycle operand-ready pulse |
| op_data | output | DW | Source operand |

## Verification
The checker watches properties that hold on every cycle. These are the single-cycle width of op_valid and its origin in a final acknowledge or a mode-0 acceptance, the stability of the read address while the block waits, the next-cycle completion of mode 0, and the frozen request latch during busy cycles. The operand values, the number of reads for each mode, and the register and PC side effects (including PC-relative immediates and indexing through the PC) can only be shown by the bench's scenarios. The bench compares these against its own register model and reads each register back through mode 0.

// File: rtl/srcop_pkg.sv
package srcop_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_PTR, ST_FIN} seq_state_t;
   typedef enum logic [2:0] {
      AM_REG    = 3'd0,
      AM_DEF    = 3'd1,
      AM_INC    = 3'd2,
      AM_INCDEF = 3'd3,
      AM_DEC    = 3'd4,
      AM_DECDEF = 3'd5,
      AM_IDX    = 3'd6,
      AM_IDXDEF = 3'd7
   } amode_t;
   typedef enum logic [1:0] {AU_PASS, AU_INC, AU_DEC, AU_ADD} au_op_t;
endpackage

// File: rtl/srcop_regfile.sv
module srcop_regfile #(
   parameter int DW          = 16,
   parameter int NREG        = 8,
   parameter int AW          = $clog2(NREG),
   parameter int INIT_BASE   = 16,
   parameter int INIT_STRIDE = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          we,
   input  logic [AW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data
);
   logic [NREG*DW-1:0] flat;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] RST_VAL = DW'(INIT_BASE + i * INIT_STRIDE);
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_VAL;
         else if (we && wr_idx == AW'(i))
            q <= wr_data;
      end
      assign flat[i*DW +: DW] = q;
   end

   assign rd_data = flat[rd_idx*DW +: DW];
endmodule

// File: rtl/srcop_addr_unit.sv
module srcop_addr_unit
   import srcop_pkg::*;
#(
   parameter int DW   = 16,
   parameter int STEP = 2
) (
   input  au_op_t        op,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] ext,
   output logic [DW-1:0] res
);
   localparam logic [DW-1:0] STEP_V = DW'(STEP);

   always_comb begin
      unique case (op)
         AU_INC:  res = base + STEP_V;
         AU_DEC:  res = base - STEP_V;
         AU_ADD:  res = base + ext;
         default: res = base;
      endcase
   end
endmodule

// File: rtl/srcop_ctrl.sv
module srcop_ctrl
   import srcop_pkg::*;
#(
   parameter int DW   = 16,
   parameter int NREG = 8,
   parameter int AW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_mode,
   input  logic [AW-1:0] req_reg,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic [DW-1:0] rd_data,
   input  logic [DW-1:0] au_res,
   output logic [AW-1:0] rd_idx,
   output au_op_t        au_op,
   output logic          we,
   output logic [AW-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic          mem_rd,
   output logic [DW-1:0] mem_addr,
   output logic          busy,
   output logic          op_valid,
   output logic [DW-1:0] op_data,
   output logic [2:0]    lat_mode,
   output logic [AW-1:0] lat_reg
);
   localparam int PC_IDX = NREG - 1;

   seq_state_t state;
   amode_t     m_in;
   amode_t     m_lat;
   logic       accept;

   assign m_in   = amode_t'(req_mode);
   assign m_lat  = amode_t'(lat_mode);
   assign accept = req_valid && (state == ST_IDLE);
   assign busy   = (state != ST_IDLE);
   assign mem_rd = (state != ST_IDLE);

   always_comb begin
      rd_idx = lat_reg;
      au_op  = AU_PASS;
      we     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            rd_idx = (m_in == AM_IDX || m_in == AM_IDXDEF) ? AW'(PC_IDX) : req_reg;
            unique case (m_in)
               AM_INC, AM_INCDEF, AM_IDX, AM_IDXDEF: au_op = AU_INC;
               AM_DEC, AM_DECDEF:                    au_op = AU_DEC;
               default:                              au_op = AU_PASS;
            endcase
            we = accept && (m_in != AM_REG) && (m_in != AM_DEF);
         end
         ST_EXT:  au_op = AU_ADD;
         default: au_op = AU_PASS;
      endcase
   end

   assign wr_idx  = rd_idx;
   assign wr_data = au_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mem_addr <= '0;
         op_valid <= 1'b0;
         op_data  <= '0;
         lat_mode <= '0;
         lat_reg  <= '0;
      end else begin
         op_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  lat_mode <= req_mode;
                  lat_reg  <= req_reg;
                  unique case (m_in)
                     AM_REG: begin
                        op_data  <= rd_data;
                        op_valid <= 1'b1;
                     end
                     AM_DEF, AM_INC: begin
                        mem_addr <= rd_data;
                        state    <= ST_FIN;
                     end
                     AM_INCDEF: begin
                        mem_addr <= rd_data;
                        state    <= ST_PTR;
                     end
                     AM_DEC: begin
                        mem_addr <= au_res;
                        state    <= ST_FIN;
                     end
                     AM_DECDEF: begin
                        mem_addr <= au_res;
                        state    <= ST_PTR;
                     end
                     default: begin
                        mem_addr <= rd_data;
                        state    <= ST_EXT;
                     end
                  endcase
               end
            end
            ST_EXT: begin
               if (mem_ack) begin
                  mem_addr <= au_res;
                  state    <= (m_lat == AM_IDXDEF) ? ST_PTR : ST_FIN;
               end
            end
            ST_PTR: begin
               if (mem_ack) begin
                  mem_addr <= mem_rdata;
                  state    <= ST_FIN;
               end
            end
            default: begin
               if (mem_ack) begin
                  op_data  <= mem_rdata;
                  op_valid <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/srcop_fetch.sv
module srcop_fetch
   import srcop_pkg::*;
#(
   parameter int DW          = 16,
   parameter int NREG        = 8,
   parameter int STEP        = 2,
   parameter int INIT_BASE   = 16,
   parameter int INIT_STRIDE = 256,
   localparam int AW         = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_mode,
   input  logic [AW-1:0] req_reg,
   output logic          busy,
   output logic          mem_rd,
   output logic [DW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          op_valid,
   output logic [DW-1:0] op_data
);
   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8");
   end
   if (STEP < 1 || STEP >= (1 << (DW - 1))) begin : g_bad_step
      $error("STEP out of range for DW");
   end

   logic [AW-1:0] rd_idx, wr_idx, lat_reg;
   logic [DW-1:0] rd_data, wr_data, au_res;
   logic          we;
   logic [2:0]    lat_mode;
   au_op_t        au_op;

   srcop_regfile #(
      .DW(DW), .NREG(NREG), .AW(AW),
      .INIT_BASE(INIT_BASE), .INIT_STRIDE(INIT_STRIDE)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .we(we), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   srcop_addr_unit #(.DW(DW), .STEP(STEP)) u_au (
      .op(au_op), .base(rd_data), .ext(mem_rdata), .res(au_res)
   );

   srcop_ctrl #(.DW(DW), .NREG(NREG), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_mode(req_mode), .req_reg(req_reg),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rd_data(rd_data), .au_res(au_res),
      .rd_idx(rd_idx), .au_op(au_op),
      .we(we), .wr_idx(wr_idx), .wr_data(wr_data),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy),
      .op_valid(op_valid), .op_data(op_data),
      .lat_mode(lat_mode), .lat_reg(lat_reg)
   );
endmodule

// File: rtl/srcop_fetch_chk.sv
module srcop_fetch_chk #(
   parameter int DW = 16,
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [2:0]    req_mode,
   input logic          busy,
   input logic          mem_rd,
   input logic [DW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          op_valid,
   input logic [2:0]    lat_mode,
   input logic [AW-1:0] lat_reg
);
   assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> !op_valid);

   assert_valid_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> ($past(mem_ack && mem_rd) || $past(req_valid && !busy && req_mode == 3'd0)));

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

   assert_reg_mode_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mode == 3'd0) |=> (op_valid && !busy));

   assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(lat_mode) && $stable(lat_reg)));
endmodule

bind srcop_fetch srcop_fetch_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
   .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack),
   .op_valid(op_valid), .lat_mode(lat_mode), .lat_reg(lat_reg)
);

// File: tb/tb_srcop_fetch.sv
module tb_srcop_fetch;
   localparam int DW = 16;
   localparam int AW = 3;

   typedef struct packed {
      logic [2:0] mode;
      logic [2:0] rg;
      logic [1:0] lat;
   } vec_t;

   localparam vec_t VEC [16] = '{
      '{3'd0, 3'd3, 2'd0}, '{3'd1, 3'd1, 2'd0}, '{3'd1, 3'd4, 2'd2}, '{3'd2, 3'd3, 2'd1},
      '{3'd2, 3'd7, 2'd0}, '{3'd3, 3'd6, 2'd2}, '{3'd4, 3'd2, 2'd0}, '{3'd4, 3'd7, 2'd1},
      '{3'd5, 3'd5, 2'd3}, '{3'd6, 3'd1, 2'd0}, '{3'd6, 3'd7, 2'd2}, '{3'd7, 3'd4, 2'd1},
      '{3'd7, 3'd7, 2'd0}, '{3'd3, 3'd7, 2'd1}, '{3'd5, 3'd0, 2'd2}, '{3'd2, 3'd0, 2'd3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_mode = '0;
   logic [AW-1:0] req_reg = '0;
   logic          busy, mem_rd, op_valid;
   logic [DW-1:0] mem_addr, op_data;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #10 clk = ~clk;

   srcop_fetch dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_reg(req_reg), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .op_valid(op_valid), .op_data(op_data)
   );

   int errors = 0;
   int checks = 0;
   int reads = 0;
   int lat_cfg = 0;
   int valids = 0;
   int hold_bad = 0;
   int wcnt = 0;
   bit waiting = 0;
   bit finished = 0;
   logic [DW-1:0] held_addr = '0;
   logic [DW-1:0] m [8];

   function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
      return {a[7:0], a[15:8]} ^ 16'h3C5A;
   endfunction

   function automatic string mtag(input int md);
      case (md)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         default: return "R9";
      endcase
   endfunction

   // memory responder: acknowledge after lat_cfg waiting cycles
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wcnt = 0;
         waiting = 0;
      end else if (mem_rd) begin
         if (waiting && mem_addr != held_addr) hold_bad++;
         held_addr = mem_addr;
         waiting = 1;
         if (wcnt >= lat_cfg) begin
            mem_ack = 1'b1;
            mem_rdata = memf(mem_addr);
            reads++;
         end else begin
            wcnt++;
         end
      end
   end

   always @(negedge clk) if (op_valid) valids++;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] md, input logic [2:0] rg, output logic [DW-1:0] res);
      int guard = 0;
      @(negedge clk);
      req_valid = 1'b1; req_mode = md; req_reg = rg;
      @(negedge clk);
      req_valid = 1'b0;
      while (!op_valid && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      res = op_data;
      @(negedge clk);
      check(!op_valid, "R11", "valid pulse width", 16'(op_valid), 16'd0);
   endtask

   task automatic readback(input int idx, input string req);
      logic [DW-1:0] v;
      issue(3'd0, 3'(idx), v);
      check(v == m[idx], req, $sformatf("register %0d readback", idx), v, m[idx]);
   endtask

   task automatic run_vec(input int md, input int rg, input int lat);
      logic [DW-1:0] e, x, got;
      int n;
      lat_cfg = lat;
      case (md)
         0: begin e = m[rg]; n = 0; end
         1: begin e = memf(m[rg]); n = 1; end
         2: begin e = memf(m[rg]); m[rg] = m[rg] + 16'd2; n = 1; end
         3: begin e = memf(memf(m[rg])); m[rg] = m[rg] + 16'd2; n = 2; end
         4: begin m[rg] = m[rg] - 16'd2; e = memf(m[rg]); n = 1; end
         5: begin m[rg] = m[rg] - 16'd2; e = memf(memf(m[rg])); n = 2; end
         6: begin x = memf(m[7]); m[7] = m[7] + 16'd2; e = memf(m[rg] + x); n = 2; end
         default: begin x = memf(m[7]); m[7] = m[7] + 16'd2; e = memf(memf(m[rg] + x)); n = 3; end
      endcase
      reads = 0;
      issue(3'(md), 3'(rg), got);
      check(got == e, mtag(md), $sformatf("operand mode %0d reg %0d", md, rg), got, e);
      check(reads == n, mtag(md), "read count", 16'(reads), 16'(n));
      readback(rg, mtag(md));
      if (rg != 7) readback(7, mtag(md));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] got, e;
      int vbase;
      int guard;
      for (int i = 0; i < 8; i++) m[i] = 16'h0010 + 16'(i) * 16'h0100;
      repeat (3) @(negedge clk);
      check(!busy, "R1", "busy in reset", 16'(busy), 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_rd, "R1", "idle after reset", {14'd0, busy, mem_rd}, 16'd0);
      check(!op_valid, "R1", "op_valid after reset", 16'(op_valid), 16'd0);
      for (int i = 0; i < 8; i++) readback(i, "R1");

      for (int i = 0; i < 16; i++) run_vec(int'(VEC[i].mode), int'(VEC[i].rg), int'(VEC[i].lat));

      // R12: request while busy is ignored
      lat_cfg = 3;
      vbase = valids;
      e = memf(memf(m[2]));
      @(negedge clk);
      req_valid = 1'b1; req_mode = 3'd3; req_reg = 3'd2;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(busy, "R12", "busy during sequence", 16'(busy), 16'd1);
      req_valid = 1'b1; req_mode = 3'd4; req_reg = 3'd5;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!op_valid && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      got = op_data;
      m[2] = m[2] + 16'd2;
      check(got == e, "R12", "operand unaffected by busy request", got, e);
      repeat (6) @(negedge clk);
      check(valids - vbase == 1, "R12", "single valid pulse", 16'(valids - vbase), 16'd1);
      check(!busy, "R12", "idle after ignored request", 16'(busy), 16'd0);
      readback(5, "R12");
      readback(2, "R12");

      check(hold_bad == 0, "R10", "address stable while waiting", 16'(hold_bad), 16'd0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule